// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a set of small memory-mapped control and status registers for a workstation I/O controller. A simple register bus reaches the registers. Each register has its own select line, and byte enables give the access width. Most registers are plain storage. A few bits cause actions instead of being stored: a one-clock floppy terminal-count pulse, a power-off request pulse and a system-reset request pulse.

A level power-fail input passes through a synchronizer. While the power-fail interrupt is enabled, this input is copied into a status bit every cycle. The interrupt line is the AND of that status bit and its enable. Software clears the status bit by writing a clear bit to the powerdown register. Block reset clears some registers. The diagnostic, LED and system-control registers keep their contents across reset, so firmware can read them after a restart.

Top module: `aux_ctrl_bank`

## Requirements
- R1: `irq` is high exactly when configuration bit 3 is set and powerdown status bit 5 is set.
- R2: While configuration bit 3 is set, powerdown bit 5 takes the value of the synchronized `pwr_fail` level. Three clock edges separate an input change from the status bit. While bit 3 is clear, status bit 5 holds its value.
- R3: A powerdown write keeps only data bits 0 and 1. Bit 1 clears status bit 5 and is never stored. Without bit 1, the existing status bit is kept. A read returns the status bit in bit 5 and the stored bit 0 in bit 0, with all other bits zero.
- R4: A powerdown write with data bit 0 set stores bit 0 and raises `poweroff_req` for exactly one cycle, in the cycle after the write.
- R5: A miscellaneous-register write with data bit 1 set raises `tc_pulse` for exactly one cycle, in the cycle after the write. The register stores the write data with bit 1 forced to 0.
- R6: A system-control write with data bit 0 set loads the register with 0x00000002 and raises `sysreset_req` for one cycle. A write with bit 0 clear changes nothing.
- R7: Reset clears the configuration, modem, miscellaneous and powerdown registers, which drops `irq`. The diagnostic, LED and system-control registers keep their values.
- R8: The `sel` bits are: bit 0 configuration, 1 diagnostic, 2 modem, 3 miscellaneous, 4 powerdown, 5 LED, 6 system control. An access needs exactly one `sel` bit set. It also needs `be` equal to 4'b0001 for the 8-bit registers, 4'b0011 for LED and 4'b1111 for system control. Any other access writes nothing and reads 0.
- R9: A configuration write with bit 3 clear drops `irq` in the next cycle and leaves status bit 5 unchanged.
- R10: The configuration, diagnostic and modem registers store 8 bits and the LED register stores 16 bits. Reads return the stored value zero-extended, combinationally, in the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sel | input | 7 | One-hot register select |
| be | input | 4 | Byte enables (access width) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when no valid read |
| pwr_fail | input | 1 | Asynchronous power-fail level |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | One-clock floppy terminal-count pulse |
| poweroff_req | output | 1 | One-cycle power-off request |
| sysreset_req | output | 1 | One-cycle system-reset request |

## Verification
A wrong power-fail status bit appears on `irq` in the same cycle whenever the enable is set, and on a powerdown read at any time. A status bit that fails to clear shows up one cycle after the clear write. If the terminal-count bit is stored by mistake, a later read of the miscellaneous register shows it. A pulse that is stuck or missing is visible on its output port one cycle after the write. A reset that clears too much or too little shows up on the first read after reset.

// File: rtl/aux_ctrl_pkg.sv
// Package: register indices, bit positions and access widths for the
// auxiliary control bank. Assumes a 32-bit data bus.
package aux_ctrl_pkg;
    localparam int NREG     = 7;
    localparam int IDX_CFG  = 0;
    localparam int IDX_DIAG = 1;
    localparam int IDX_MDM  = 2;
    localparam int IDX_MISC = 3;
    localparam int IDX_PDN  = 4;
    localparam int IDX_LED  = 5;
    localparam int IDX_SYS  = 6;

    localparam int CFG_PFEN = 3;
    localparam int PDN_OFF  = 0;
    localparam int PDN_CLR  = 1;
    localparam int PDN_STAT = 5;
    localparam int MISC_TC  = 1;
    localparam int SYS_GO   = 0;
    localparam logic [31:0] SYS_DONE = 32'h0000_0002;

    // Number of bytes a register needs per access
    function automatic int reg_bytes(input int idx);
        case (idx)
            IDX_LED: return 2;
            IDX_SYS: return 4;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/aux_pf_sync.sv
// Multi-stage synchronizer for the asynchronous power-fail level.
// Assumes STAGES >= 2; the reset value is "no failure".
module aux_pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/aux_bus_decode.sv
// Access decoder: turns the select lines, byte enables and strobes into
// per-register read and write strobes. An access counts only if exactly
// one select is set and the byte enables match that register's width.
module aux_bus_decode
    import aux_ctrl_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [NREG-1:0] sel,
    input  logic [BE_W-1:0] be,
    output logic [NREG-1:0] wr_stb,
    output logic [NREG-1:0] rd_stb
);
    logic sel_ok;

    // A valid access selects a single register
    assign sel_ok = $onehot(sel);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [BE_W-1:0] need_be;
        logic            hit;
        assign need_be   = BE_W'((1 << reg_bytes(i)) - 1);
        assign hit       = sel_ok && sel[i] && (be == need_be);
        assign wr_stb[i] = wr_en && hit;
        assign rd_stb[i] = rd_en && hit;
    end
endmodule

// File: rtl/aux_pwr_ctrl.sv
// Powerdown register and power-fail status latch. The status bit takes the
// synchronized level every cycle while enabled. A powerdown write has
// priority over sampling in its cycle: it either clears the status bit or
// holds it. Also produces the one-cycle power-off request.
module aux_pwr_ctrl
    import aux_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pf_lvl,
    input  logic       pf_en,
    input  logic       wr_stb,
    input  logic       wr_off,
    input  logic       wr_clr,
    output logic [7:0] pdn_q,
    output logic       pf_stat,
    output logic       off_req
);
    logic off_bit;

    // Status latch: write clear wins, write holds, else follow input when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)                pf_stat <= 1'b0;
        else if (wr_stb && wr_clr) pf_stat <= 1'b0;
        else if (!wr_stb && pf_en) pf_stat <= pf_lvl;
    end

    // Stored power-off bit and its request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_bit <= 1'b0;
            off_req <= 1'b0;
        end else begin
            if (wr_stb) off_bit <= wr_off;
            off_req <= wr_stb && wr_off;
        end
    end

    // Readable image of the powerdown register
    always_comb begin
        pdn_q           = '0;
        pdn_q[PDN_OFF]  = off_bit;
        pdn_q[PDN_STAT] = pf_stat;
    end
endmodule

// File: rtl/aux_ctrl_bank.sv
// Top of the auxiliary control bank. Holds the plain storage registers,
// the side-effect bits and the read multiplexer. Assumes DATA_W == 32.
// Diagnostic, LED and system-control registers have no reset on purpose.
module aux_ctrl_bank
    import aux_ctrl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [NREG-1:0]   sel,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pwr_fail,
    output logic              irq,
    output logic              tc_pulse,
    output logic              poweroff_req,
    output logic              sysreset_req
);
    localparam int BE_W = DATA_W / 8;

    logic [NREG-1:0] wr_stb, rd_stb;
    logic [7:0]      cfg_q, diag_q, mdm_q, misc_q, pdn_q;
    logic [15:0]     led_q;
    logic [31:0]     sys_q;
    logic            pf_lvl, pf_stat;
    logic            unused_wdata;

    assign unused_wdata = ^wr_data[DATA_W-1:16];

    aux_pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwr_fail),
        .sync_out (pf_lvl)
    );

    aux_bus_decode #(.BE_W(BE_W)) u_dec (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .sel    (sel),
        .be     (be),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb)
    );

    aux_pwr_ctrl u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_lvl  (pf_lvl),
        .pf_en   (cfg_q[CFG_PFEN]),
        .wr_stb  (wr_stb[IDX_PDN]),
        .wr_off  (wr_data[PDN_OFF]),
        .wr_clr  (wr_data[PDN_CLR]),
        .pdn_q   (pdn_q),
        .pf_stat (pf_stat),
        .off_req (poweroff_req)
    );

    // Registers cleared by reset: configuration, modem, miscellaneous
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mdm_q  <= '0;
            misc_q <= '0;
        end else begin
            if (wr_stb[IDX_CFG])  cfg_q  <= wr_data[7:0];
            if (wr_stb[IDX_MDM])  mdm_q  <= wr_data[7:0];
            if (wr_stb[IDX_MISC]) misc_q <= wr_data[7:0] & ~(8'(1) << MISC_TC);
        end
    end

    // Terminal-count and system-reset request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_pulse     <= 1'b0;
            sysreset_req <= 1'b0;
        end else begin
            tc_pulse     <= wr_stb[IDX_MISC] && wr_data[MISC_TC];
            sysreset_req <= wr_stb[IDX_SYS] && wr_data[SYS_GO];
        end
    end

    // Registers that survive reset: diagnostic, LED, system control
    always_ff @(posedge clk) begin
        if (wr_stb[IDX_DIAG]) diag_q <= wr_data[7:0];
        if (wr_stb[IDX_LED])  led_q  <= wr_data[15:0];
        if (wr_stb[IDX_SYS] && wr_data[SYS_GO]) sys_q <= SYS_DONE;
    end

    // Power-fail interrupt from enable and status
    assign irq = cfg_q[CFG_PFEN] & pf_stat;

    // Read multiplexer, zero unless a valid read is decoded
    always_comb begin
        rd_data = '0;
        if (rd_stb[IDX_CFG])  rd_data = DATA_W'(cfg_q);
        if (rd_stb[IDX_DIAG]) rd_data = DATA_W'(diag_q);
        if (rd_stb[IDX_MDM])  rd_data = DATA_W'(mdm_q);
        if (rd_stb[IDX_MISC]) rd_data = DATA_W'(misc_q);
        if (rd_stb[IDX_PDN])  rd_data = DATA_W'(pdn_q);
        if (rd_stb[IDX_LED])  rd_data = DATA_W'(led_q);
        if (rd_stb[IDX_SYS])  rd_data = DATA_W'(sys_q);
    end
endmodule

// File: rtl/aux_ctrl_bank_chk.sv
// Checker for aux_ctrl_bank: relates the request pulses and the interrupt
// to the bus accesses that cause them. Attached with bind below.
module aux_ctrl_bank_chk
    import aux_ctrl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [NREG-1:0] sel,
    input logic [3:0]      be,
    input logic [31:0]     wr_data,
    input logic            irq,
    input logic            tc_pulse,
    input logic            poweroff_req,
    input logic            sysreset_req
);
    logic w8_ok;
    assign w8_ok = wr_en && $onehot(sel) && (be == 4'b0001);

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse); // R5
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(w8_ok && sel[IDX_MISC] && wr_data[MISC_TC])); // R5
    AST_POFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |-> $past(w8_ok && sel[IDX_PDN] && wr_data[PDN_OFF])); // R4
    AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |-> $past(wr_en && $onehot(sel) && sel[IDX_SYS] && be == 4'hF && wr_data[SYS_GO])); // R6
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (w8_ok && sel[IDX_PDN] && wr_data[PDN_CLR]) |=> !irq); // R3
    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (w8_ok && sel[IDX_CFG] && !wr_data[CFG_PFEN]) |=> !irq); // R9
    AST_WIDTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_MISC] && be != 4'b0001) |=> !tc_pulse); // R8
endmodule

bind aux_ctrl_bank aux_ctrl_bank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .sel          (sel),
    .be           (be),
    .wr_data      (wr_data),
    .irq          (irq),
    .tc_pulse     (tc_pulse),
    .poweroff_req (poweroff_req),
    .sysreset_req (sysreset_req)
);

// File: tb/aux_ctrl_bank_bench.sv
// Scoreboard bench: driver tasks queue expected values with the negedge
// count at which they fall due; a monitor compares at each negedge.
module aux_ctrl_bank_bench;
    localparam int S_RD = 0, S_IRQ = 1, S_TC = 2, S_POFF = 3, S_SRST = 4;
    localparam logic [6:0] CFG = 7'h01, DIAG = 7'h02, MDM = 7'h04, MISC = 7'h08,
                           PDN = 7'h10, LED = 7'h20, SYS = 7'h40;

    typedef struct {
        int          due;
        int          sig;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, pwr_fail = 0;
    logic [6:0]  sel = '0;
    logic [3:0]  be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, tc_pulse, poweroff_req, sysreset_req;

    item_t q[$];
    int ncnt = 0, checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    aux_ctrl_bank u_aux_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .be(be), .wr_data(wr_data), .rd_data(rd_data), .pwr_fail(pwr_fail),
        .irq(irq), .tc_pulse(tc_pulse), .poweroff_req(poweroff_req),
        .sysreset_req(sysreset_req)
    );

    // Monitor: compare every item due at this negedge
    always @(negedge clk) begin
        logic [31:0] act;
        ncnt++;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == ncnt) begin
                case (q[i].sig)
                    S_RD:    act = rd_data;
                    S_IRQ:   act = {31'b0, irq};
                    S_TC:    act = {31'b0, tc_pulse};
                    S_POFF:  act = {31'b0, poweroff_req};
                    default: act = {31'b0, sysreset_req};
                endcase
                checks++;
                if (act !== q[i].exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", q[i].tag, act, q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    task automatic push(input int due, input int sig, input logic [31:0] exp, input string tag);
        item_t it;
        it.due = due; it.sig = sig; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Expect a value 'off' cycles after the next driven operation
    task automatic arm(input int sig, input logic [31:0] exp, input int off, input string tag);
        push(ncnt + 1 + off, sig, exp, tag);
    endtask

    task automatic idle();
        @(negedge clk); #1;
        wr_en = 0; rd_en = 0; sel = '0; be = '0; wr_data = '0;
    endtask

    task automatic wr(input logic [6:0] s, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1; sel = s; be = b; wr_data = d;
        idle();
    endtask

    task automatic rd_chk(input logic [6:0] s, input logic [3:0] b, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        rd_en = 1; sel = s; be = b;
        push(ncnt + 1, S_RD, exp, tag);
        idle();
    endtask

    task automatic chk_now(input int sig, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        push(ncnt + 1, sig, exp, tag);
        @(negedge clk); #1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1;
        // Reset state
        chk_now(S_IRQ, 0, "R7 irq after reset");
        rd_chk(CFG, 4'h1, 32'h0, "R7 cfg reset");
        rd_chk(PDN, 4'h1, 32'h0, "R7 pdn reset");
        rd_chk(MISC, 4'h1, 32'h0, "R7 misc reset");
        rd_chk(MDM, 4'h1, 32'h0, "R7 mdm reset");
        // Plain storage
        wr(DIAG, 4'h1, 32'hFFFF_FFA5);
        rd_chk(DIAG, 4'h1, 32'hA5, "R10 diag store");
        wr(MDM, 4'h1, 32'h3C);
        rd_chk(MDM, 4'h1, 32'h3C, "R10 mdm store");
        wr(LED, 4'h3, 32'h1234_BEEF);
        rd_chk(LED, 4'h3, 32'hBEEF, "R10 led store");
        wr(CFG, 4'h1, 32'h81);
        rd_chk(CFG, 4'h1, 32'h81, "R10 cfg store");
        // Width and select rules
        wr(DIAG, 4'hF, 32'h11);
        rd_chk(DIAG, 4'h1, 32'hA5, "R8 diag wide write ignored");
        wr(LED, 4'h1, 32'h11);
        rd_chk(LED, 4'h3, 32'hBEEF, "R8 led narrow write ignored");
        rd_chk(DIAG, 4'h3, 32'h0, "R8 wrong-width read is zero");
        wr(DIAG | MDM, 4'h1, 32'h77);
        rd_chk(MDM, 4'h1, 32'h3C, "R8 two-select write ignored");
        arm(S_TC, 0, 1, "R8 misc wide write no pulse");
        wr(MISC, 4'h3, 32'h02);
        // Terminal count
        arm(S_TC, 1, 1, "R5 tc pulse high");
        arm(S_TC, 0, 2, "R5 tc pulse one clock");
        wr(MISC, 4'h1, 32'hFF);
        rd_chk(MISC, 4'h1, 32'hFD, "R5 tc bit not stored");
        arm(S_TC, 0, 1, "R5 no pulse without bit");
        wr(MISC, 4'h1, 32'h01);
        // System control
        arm(S_SRST, 1, 1, "R6 sysreset pulse");
        arm(S_SRST, 0, 2, "R6 sysreset one cycle");
        wr(SYS, 4'hF, 32'hFFFF_FFFF);
        rd_chk(SYS, 4'hF, 32'h2, "R6 sys status value");
        arm(S_SRST, 0, 1, "R6 bit0 clear no pulse");
        wr(SYS, 4'hF, 32'hFFFF_FFFE);
        rd_chk(SYS, 4'hF, 32'h2, "R6 bit0 clear no change");
        // Power fail with enable
        wr(CFG, 4'h1, 32'h08);
        pwr_fail = 1;
        settle();
        chk_now(S_IRQ, 1, "R1 irq with enable and status");
        rd_chk(PDN, 4'h1, 32'h20, "R2 status follows input");
        // Disable drops irq, keeps status
        arm(S_IRQ, 0, 1, "R9 irq drops on disable");
        wr(CFG, 4'h1, 32'h00);
        rd_chk(PDN, 4'h1, 32'h20, "R9 status kept");
        pwr_fail = 0;
        settle();
        rd_chk(PDN, 4'h1, 32'h20, "R2 status held while disabled");
        // Write-to-clear
        wr(PDN, 4'h1, 32'h02);
        rd_chk(PDN, 4'h1, 32'h00, "R3 clear bit clears status, not stored");
        wr(CFG, 4'h1, 32'h08);
        pwr_fail = 1;
        settle();
        chk_now(S_IRQ, 1, "R1 irq re-raised");
        arm(S_POFF, 0, 1, "R4 no poweroff without bit0");
        wr(PDN, 4'h1, 32'hFC);
        rd_chk(PDN, 4'h1, 32'h20, "R3 upper bits dropped, status merged");
        arm(S_IRQ, 0, 1, "R3 irq cleared by write");
        arm(S_POFF, 1, 1, "R4 poweroff pulse");
        arm(S_POFF, 0, 2, "R4 poweroff one cycle");
        arm(S_IRQ, 1, 2, "R2 status resampled after clear");
        wr(PDN, 4'h1, 32'h03);
        pwr_fail = 0;
        settle();
        rd_chk(PDN, 4'h1, 32'h01, "R4 poweroff bit stored, status follows low");
        // Selective reset
        pwr_fail = 1;
        wr(DIAG, 4'h1, 32'h5A);
        wr(MISC, 4'h1, 32'h41);
        settle();
        chk_now(S_IRQ, 1, "R1 irq before reset");
        @(negedge clk); #1 rst_n = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
        chk_now(S_IRQ, 0, "R7 irq cleared by reset");
        rd_chk(CFG, 4'h1, 32'h0, "R7 cfg cleared");
        rd_chk(MDM, 4'h1, 32'h0, "R7 mdm cleared");
        rd_chk(MISC, 4'h1, 32'h0, "R7 misc cleared");
        rd_chk(PDN, 4'h1, 32'h0, "R7 pdn cleared");
        rd_chk(DIAG, 4'h1, 32'h5A, "R7 diag kept");
        rd_chk(LED, 4'h3, 32'hBEEF, "R7 led kept");
        rd_chk(SYS, 4'hF, 32'h2, "R7 sys kept");
        repeat (3) @(negedge clk);
        #1;
        if (q.size() != 0) begin
            fails++; checks++;
            $display("FAIL scoreboard: actual %0d expected 0 pending items", q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule